// File: doc/BRIEF.md
# Alarm and Periodic Event Controller

This block sits beside a calendar time counter and turns its state into two interrupt sources. The alarm source compares the running BCD time against a set of programmable alarm fields on every seconds update. Only the fields whose range-enable bit is set take part in the compare. The periodic source watches a vector of carry strobes from the counter chain, covering intervals from 1/1024 s up to 10 minutes, and fires whenever the selected carry strobes.

Each source has a sticky flag, a mask bit and a mode bit. In level mode (mode 0) the active-low output follows the unmasked flag, and software can clear the flag only by writing a 0 to it. In pulse mode (mode 1) every unmasked event drives the output low for a fixed number of oscillator ticks, and a read of the flag register clears the flag. A third output is low whenever either source output is low. None of the outputs depends on any select signal.

Top module: `rtc_event_ctrl`

## Requirements
- R1: After reset all three outputs are high, both flags are 0, both mask bits are 1, both mode bits are 0, and the carry select, the range enables and all alarm fields are 0.
- R2: In a cycle with `sec_tick` high, the alarm flag sets if every enabled field equals its alarm register. The range-enable bits are bit0 second, bit1 minute, bit2 hour together with PM, bit3 day, bit4 month and bit5 weekday. With no field enabled, every `sec_tick` matches. Without `sec_tick` no alarm event occurs.
- R3: In a cycle where `carry_in[carry_sel]` is high, the periodic flag sets. The carry select sits in control register bits 6:4.
- R4: The periodic mask is control bit0 and the alarm mask is control bit1. A mask bit of 1 holds its output high, but its flag still sets on events.
- R5: In level mode, the output is low in every cycle in which the flag is set and the mask is 0. The periodic mode bit is control bit2 and the alarm mode bit is control bit3.
- R6: In pulse mode, each unmasked event drives the output low from the next cycle for exactly PULSE_TICKS `osc_tick` strobes. The flag does not drive the output in this mode.
- R7: The flag register is at address 8, with bit0 periodic and bit1 alarm. A read of it clears a flag whose mode bit is 1, starting the next cycle. A flag whose mode bit is 0 is left unchanged by the read.
- R8: A write to address 8 clears each flag whose written bit is 0 and leaves unchanged each flag whose written bit is 1, in either mode.
- R9: An event in the same cycle as a read-clear or a write-clear leaves its flag set.
- R10: `any_irq_n` is low exactly when `per_irq_n` or `alm_irq_n` is low.
- R11: Register map:
  - Addresses 0 to 5 hold the alarm second (7 bits), minute (7), hour (bits 5:0, with PM at bit6), day (6), month (5) and weekday (3).
  - Address 6 holds the range enables in bits 5:0.
  - Address 7 holds the control bits in 6:0.
  - Unimplemented bits and unmapped addresses read 0.
  - Read data is combinational from the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | Oscillator strobe that times output pulses |
| sec_tick | input | 1 | Seconds update strobe |
| carry_in | input | NUM_CARRY | Carry strobes from the time counter chain |
| time_sec | input | 7 | Current seconds, BCD |
| time_min | input | 7 | Current minutes, BCD |
| time_hour | input | 6 | Current hour, BCD |
| time_pm | input | 1 | Current PM indicator |
| time_day | input | 6 | Current day of month, BCD |
| time_mon | input | 5 | Current month, BCD |
| time_wday | input | 3 | Current weekday, 0 to 6 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| per_irq_n | output | 1 | Periodic output, active low |
| alm_irq_n | output | 1 | Alarm output, active low |
| any_irq_n | output | 1 | Combined output, active low |

## Verification
Read data depends only on the address and current state. The bench therefore samples it 1 ns after driving the inputs, in the same cycle. Flags, outputs and register writes change at the first rising edge after the strobe. The bench checks them at the falling edge that follows, against a model that it updates once per driven cycle from the values held before that edge. A pulse-mode event is followed through PULSE_TICKS further tick cycles, so the return of the output to high is checked at the exact cycle it is due.

// File: rtl/rtc_evt_pkg.sv
package rtc_evt_pkg;
    localparam int NUM_FIELDS = 6;
    localparam int SEL_W      = 3;

    typedef enum logic [3:0] {
        ADR_SEC   = 4'd0,
        ADR_MIN   = 4'd1,
        ADR_HOUR  = 4'd2,
        ADR_DAY   = 4'd3,
        ADR_MON   = 4'd4,
        ADR_WDAY  = 4'd5,
        ADR_RANGE = 4'd6,
        ADR_CTRL  = 4'd7,
        ADR_FLAG  = 4'd8
    } reg_addr_e;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic       pm;
        logic [5:0] day;
        logic [4:0] mon;
        logic [2:0] wday;
    } alarm_regs_t;

    typedef struct packed {
        logic [SEL_W-1:0] carry_sel;
        logic             alm_mode;
        logic             per_mode;
        logic             alm_mask;
        logic             per_mask;
    } ctrl_t;
endpackage

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_evt_pkg::*;
(
    input  alarm_regs_t           alm,
    input  logic [6:0]            t_sec,
    input  logic [6:0]            t_min,
    input  logic [5:0]            t_hour,
    input  logic                  t_pm,
    input  logic [5:0]            t_day,
    input  logic [4:0]            t_mon,
    input  logic [2:0]            t_wday,
    input  logic [NUM_FIELDS-1:0] range_en,
    output logic                  match
);
    logic [7:0]            tv [NUM_FIELDS];
    logic [7:0]            av [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] hit;

    always_comb begin
        tv[0] = {1'b0, t_sec};
        tv[1] = {1'b0, t_min};
        tv[2] = {1'b0, t_pm, t_hour};
        tv[3] = {2'b0, t_day};
        tv[4] = {3'b0, t_mon};
        tv[5] = {5'b0, t_wday};
        av[0] = {1'b0, alm.sec};
        av[1] = {1'b0, alm.min};
        av[2] = {1'b0, alm.pm, alm.hour};
        av[3] = {2'b0, alm.day};
        av[4] = {3'b0, alm.mon};
        av[5] = {5'b0, alm.wday};
    end

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        assign hit[i] = !range_en[i] || (tv[i] == av[i]);
    end

    assign match = &hit;
endmodule

// File: rtl/rtc_evt_channel.sv
module rtc_evt_channel #(
    parameter int PULSE_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic event_i,
    input  logic mode_i,
    input  logic mask_i,
    input  logic rd_clr_i,
    input  logic wr_clr_i,
    output logic flag_o,
    output logic active_o
);
    localparam int CNT_W = $clog2(PULSE_TICKS + 1);

    typedef struct packed {
        logic             flag;
        logic [CNT_W-1:0] cnt;
    } ch_state_t;

    ch_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if ((rd_clr_i && mode_i) || wr_clr_i) s_d.flag = 1'b0;
        if (event_i)                          s_d.flag = 1'b1;
        if (event_i && mode_i && !mask_i)
            s_d.cnt = CNT_W'(PULSE_TICKS);
        else if (osc_tick && s_q.cnt != '0)
            s_d.cnt = s_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flag_o   = s_q.flag;
    assign active_o = !mask_i && (mode_i ? (s_q.cnt != '0) : s_q.flag);
endmodule

// File: rtl/rtc_event_ctrl.sv
module rtc_event_ctrl
    import rtc_evt_pkg::*;
#(
    parameter int NUM_CARRY   = 8,
    parameter int PULSE_TICKS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 osc_tick,
    input  logic                 sec_tick,
    input  logic [NUM_CARRY-1:0] carry_in,
    input  logic [6:0]           time_sec,
    input  logic [6:0]           time_min,
    input  logic [5:0]           time_hour,
    input  logic                 time_pm,
    input  logic [5:0]           time_day,
    input  logic [4:0]           time_mon,
    input  logic [2:0]           time_wday,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [3:0]           reg_addr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    output logic                 per_irq_n,
    output logic                 alm_irq_n,
    output logic                 any_irq_n
);
    typedef struct packed {
        alarm_regs_t           alm;
        logic [NUM_FIELDS-1:0] range_en;
        ctrl_t                 ctrl;
    } top_state_t;

    localparam ctrl_t CTRL_RST = '{carry_sel: '0, alm_mode: 1'b0, per_mode: 1'b0,
                                   alm_mask: 1'b1, per_mask: 1'b1};

    top_state_t st_d, st_q;

    logic             per_mask, alm_mask, per_mode, alm_mode;
    logic [SEL_W-1:0] carry_sel;
    logic             alm_match, carry_hit;
    logic             per_flag, alm_flag, per_act, alm_act;
    logic             flag_sel;

    assign per_mask  = st_q.ctrl.per_mask;
    assign alm_mask  = st_q.ctrl.alm_mask;
    assign per_mode  = st_q.ctrl.per_mode;
    assign alm_mode  = st_q.ctrl.alm_mode;
    assign carry_sel = st_q.ctrl.carry_sel;
    assign flag_sel  = (reg_addr == ADR_FLAG);

    always_comb begin
        st_d = st_q;
        if (reg_wr) begin
            case (reg_addr_e'(reg_addr))
                ADR_SEC:   st_d.alm.sec  = reg_wdata[6:0];
                ADR_MIN:   st_d.alm.min  = reg_wdata[6:0];
                ADR_HOUR: begin
                    st_d.alm.hour = reg_wdata[5:0];
                    st_d.alm.pm   = reg_wdata[6];
                end
                ADR_DAY:   st_d.alm.day  = reg_wdata[5:0];
                ADR_MON:   st_d.alm.mon  = reg_wdata[4:0];
                ADR_WDAY:  st_d.alm.wday = reg_wdata[2:0];
                ADR_RANGE: st_d.range_en = reg_wdata[NUM_FIELDS-1:0];
                ADR_CTRL:  st_d.ctrl     = ctrl_t'(reg_wdata[6:0]);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.alm      <= '0;
            st_q.range_en <= '0;
            st_q.ctrl     <= CTRL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_addr_e'(reg_addr))
            ADR_SEC:   reg_rdata = {1'b0, st_q.alm.sec};
            ADR_MIN:   reg_rdata = {1'b0, st_q.alm.min};
            ADR_HOUR:  reg_rdata = {1'b0, st_q.alm.pm, st_q.alm.hour};
            ADR_DAY:   reg_rdata = {2'b0, st_q.alm.day};
            ADR_MON:   reg_rdata = {3'b0, st_q.alm.mon};
            ADR_WDAY:  reg_rdata = {5'b0, st_q.alm.wday};
            ADR_RANGE: reg_rdata = {2'b0, st_q.range_en};
            ADR_CTRL:  reg_rdata = {1'b0, st_q.ctrl};
            ADR_FLAG:  reg_rdata = {6'b0, alm_flag, per_flag};
            default:   reg_rdata = 8'h00;
        endcase
    end

    always_comb begin
        carry_hit = 1'b0;
        for (int i = 0; i < NUM_CARRY; i++)
            if (carry_sel == SEL_W'(i)) carry_hit = carry_in[i];
    end

    rtc_alarm_match u_match (
        .alm      (st_q.alm),
        .t_sec    (time_sec),
        .t_min    (time_min),
        .t_hour   (time_hour),
        .t_pm     (time_pm),
        .t_day    (time_day),
        .t_mon    (time_mon),
        .t_wday   (time_wday),
        .range_en (st_q.range_en),
        .match    (alm_match)
    );

    rtc_evt_channel #(.PULSE_TICKS(PULSE_TICKS)) u_per (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .event_i  (carry_hit),
        .mode_i   (per_mode),
        .mask_i   (per_mask),
        .rd_clr_i (reg_rd && flag_sel),
        .wr_clr_i (reg_wr && flag_sel && !reg_wdata[0]),
        .flag_o   (per_flag),
        .active_o (per_act)
    );

    rtc_evt_channel #(.PULSE_TICKS(PULSE_TICKS)) u_alm (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .event_i  (sec_tick && alm_match),
        .mode_i   (alm_mode),
        .mask_i   (alm_mask),
        .rd_clr_i (reg_rd && flag_sel),
        .wr_clr_i (reg_wr && flag_sel && !reg_wdata[1]),
        .flag_o   (alm_flag),
        .active_o (alm_act)
    );

    assign per_irq_n = !per_act;
    assign alm_irq_n = !alm_act;
    assign any_irq_n = per_irq_n & alm_irq_n;
endmodule

// File: rtl/rtc_event_ctrl_chk.sv
module rtc_event_ctrl_chk #(
    parameter int NUM_CARRY = 8,
    parameter int SEL_W     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sec_tick,
    input logic [NUM_CARRY-1:0] carry_in,
    input logic                 reg_rd,
    input logic                 reg_wr,
    input logic [3:0]           reg_addr,
    input logic                 per_irq_n,
    input logic                 alm_irq_n,
    input logic                 any_irq_n,
    input logic                 per_flag,
    input logic                 alm_flag,
    input logic                 per_mask,
    input logic                 alm_mask,
    input logic                 per_mode,
    input logic                 alm_mode,
    input logic [SEL_W-1:0]     carry_sel,
    input logic                 alm_match
);
    logic sel_carry;
    always_comb begin
        sel_carry = 1'b0;
        for (int i = 0; i < NUM_CARRY; i++)
            if (carry_sel == SEL_W'(i)) sel_carry = carry_in[i];
    end

    assert_alarm_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && alm_match) |=> alm_flag);

    assert_carry_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_carry |=> per_flag);

    assert_per_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        per_mask |-> per_irq_n);

    assert_alm_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        alm_mask |-> alm_irq_n);

    assert_level_follows_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!per_mode && !per_mask && per_flag) |-> !per_irq_n);

    assert_level_read_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && reg_addr == 4'd8 && !alm_mode && alm_flag) |=> alm_flag);

    assert_combined_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!per_irq_n || !alm_irq_n) |-> !any_irq_n);
endmodule

bind rtc_event_ctrl rtc_event_ctrl_chk #(.NUM_CARRY(NUM_CARRY), .SEL_W(rtc_evt_pkg::SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_tick  (sec_tick),
    .carry_in  (carry_in),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .per_irq_n (per_irq_n),
    .alm_irq_n (alm_irq_n),
    .any_irq_n (any_irq_n),
    .per_flag  (per_flag),
    .alm_flag  (alm_flag),
    .per_mask  (per_mask),
    .alm_mask  (alm_mask),
    .per_mode  (per_mode),
    .alm_mode  (alm_mode),
    .carry_sel (carry_sel),
    .alm_match (alm_match)
);

// File: tb/sim_rtc_event_ctrl.sv
module sim_rtc_event_ctrl;
    localparam int NC = 8;
    localparam int PT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_tick = 1'b0, sec_tick = 1'b0;
    logic [NC-1:0] carry_in = '0;
    logic [6:0] t_sec = '0, t_min = '0;
    logic [5:0] t_hour = '0, t_day = '0;
    logic t_pm = 1'b0;
    logic [4:0] t_mon = '0;
    logic [2:0] t_wday = '0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic per_irq_n, alm_irq_n, any_irq_n;

    int n_chk = 0, n_fail = 0;

    // bench model
    logic [6:0] m_sec, m_min;
    logic [5:0] m_hour, m_day, m_en;
    logic m_pm;
    logic [4:0] m_mon;
    logic [2:0] m_wday;
    logic [6:0] m_ctrl;
    logic m_pflag, m_aflag;
    int m_pcnt, m_acnt;

    always #2 clk = ~clk;

    rtc_event_ctrl #(.NUM_CARRY(NC), .PULSE_TICKS(PT)) u0 (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .sec_tick(sec_tick),
        .carry_in(carry_in), .time_sec(t_sec), .time_min(t_min), .time_hour(t_hour),
        .time_pm(t_pm), .time_day(t_day), .time_mon(t_mon), .time_wday(t_wday),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .per_irq_n(per_irq_n), .alm_irq_n(alm_irq_n),
        .any_irq_n(any_irq_n)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic m_match();
        logic ok = 1'b1;
        if (m_en[0] && t_sec != m_sec) ok = 1'b0;
        if (m_en[1] && t_min != m_min) ok = 1'b0;
        if (m_en[2] && (t_hour != m_hour || t_pm != m_pm)) ok = 1'b0;
        if (m_en[3] && t_day != m_day) ok = 1'b0;
        if (m_en[4] && t_mon != m_mon) ok = 1'b0;
        if (m_en[5] && t_wday != m_wday) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic [7:0] m_read(input logic [3:0] a);
        case (a)
            4'd0: return {1'b0, m_sec};
            4'd1: return {1'b0, m_min};
            4'd2: return {1'b0, m_pm, m_hour};
            4'd3: return {2'b0, m_day};
            4'd4: return {3'b0, m_mon};
            4'd5: return {5'b0, m_wday};
            4'd6: return {2'b0, m_en};
            4'd7: return {1'b0, m_ctrl};
            4'd8: return {6'b0, m_aflag, m_pflag};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic exp_out(input logic mask, input logic mode, input int cnt, input logic flag);
        return !(!mask && (mode ? (cnt != 0) : flag));
    endfunction

    task automatic m_reset();
        m_sec = '0; m_min = '0; m_hour = '0; m_pm = 1'b0; m_day = '0; m_mon = '0; m_wday = '0;
        m_en = '0; m_ctrl = 7'h03; m_pflag = 1'b0; m_aflag = 1'b0; m_pcnt = 0; m_acnt = 0;
    endtask

    // one driven cycle: drive after a falling edge, model the rising edge, check at next falling edge
    task automatic cyc(input logic wr, input logic rd, input logic [3:0] a, input logic [7:0] wd,
                       input logic st, input logic [NC-1:0] cy, input logic osc);
        logic pev, aev, pclr, aclr;
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        sec_tick = st; carry_in = cy; osc_tick = osc;
        #1;
        if (rd) chk((a == 4'd8) ? "R7" : "R11", reg_rdata, m_read(a));
        pev  = cy[m_ctrl[6:4]];
        aev  = st && m_match();
        pclr = (rd && a == 4'd8 && m_ctrl[2]) || (wr && a == 4'd8 && !wd[0]);
        aclr = (rd && a == 4'd8 && m_ctrl[3]) || (wr && a == 4'd8 && !wd[1]);
        if (pev && m_ctrl[2] && !m_ctrl[0]) m_pcnt = PT; else if (osc && m_pcnt != 0) m_pcnt--;
        if (aev && m_ctrl[3] && !m_ctrl[1]) m_acnt = PT; else if (osc && m_acnt != 0) m_acnt--;
        if (pclr) m_pflag = 1'b0;
        if (pev)  m_pflag = 1'b1;
        if (aclr) m_aflag = 1'b0;
        if (aev)  m_aflag = 1'b1;
        if (wr) begin
            case (a)
                4'd0: m_sec = wd[6:0];
                4'd1: m_min = wd[6:0];
                4'd2: begin m_hour = wd[5:0]; m_pm = wd[6]; end
                4'd3: m_day = wd[5:0];
                4'd4: m_mon = wd[4:0];
                4'd5: m_wday = wd[2:0];
                4'd6: m_en = wd[5:0];
                4'd7: m_ctrl = wd[6:0];
                default: ;
            endcase
        end
        @(negedge clk);
        chk(m_ctrl[0] ? "R4" : (m_ctrl[2] ? "R6" : "R5"), {7'b0, per_irq_n},
            {7'b0, exp_out(m_ctrl[0], m_ctrl[2], m_pcnt, m_pflag)});
        chk(m_ctrl[1] ? "R4" : (m_ctrl[3] ? "R6" : "R5"), {7'b0, alm_irq_n},
            {7'b0, exp_out(m_ctrl[1], m_ctrl[3], m_acnt, m_aflag)});
        chk("R10", {7'b0, any_irq_n},
            {7'b0, exp_out(m_ctrl[0], m_ctrl[2], m_pcnt, m_pflag) & exp_out(m_ctrl[1], m_ctrl[3], m_acnt, m_aflag)});
    endtask

    task automatic idle(input logic osc);
        cyc(1'b0, 1'b0, 4'd0, 8'h00, 1'b0, '0, osc);
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports
        chk("R1", {5'b0, per_irq_n, alm_irq_n, any_irq_n}, 8'h07);
        for (int a = 0; a < 10; a++) cyc(1'b0, 1'b1, 4'(a), 8'h00, 1'b0, '0, 1'b0);

        // R2: alarm compare on seconds only
        cyc(1'b1, 1'b0, 4'd7, 8'h00, 1'b0, '0, 1'b0);
        cyc(1'b1, 1'b0, 4'd0, 8'h30, 1'b0, '0, 1'b0);
        cyc(1'b1, 1'b0, 4'd6, 8'h01, 1'b0, '0, 1'b0);
        t_sec = 7'h29;
        cyc(1'b0, 1'b0, 4'd0, 8'h00, 1'b1, '0, 1'b0);
        chk("R2", {7'b0, alm_irq_n}, 8'h01);
        t_sec = 7'h30; t_min = 7'h12;
        cyc(1'b0, 1'b0, 4'd0, 8'h00, 1'b0, '0, 1'b0);
        chk("R2", {7'b0, alm_irq_n}, 8'h01);
        cyc(1'b0, 1'b0, 4'd0, 8'h00, 1'b1, '0, 1'b0);
        chk("R2", {7'b0, alm_irq_n}, 8'h00);
        chk("R10", {7'b0, any_irq_n}, 8'h00);
        // R7: level-mode read leaves flag
        cyc(1'b0, 1'b1, 4'd8, 8'h00, 1'b0, '0, 1'b0);
        chk("R7", {7'b0, alm_irq_n}, 8'h00);
        // R8: write 1 keeps, write 0 clears
        cyc(1'b1, 1'b0, 4'd8, 8'hFF, 1'b0, '0, 1'b0);
        chk("R8", {7'b0, alm_irq_n}, 8'h00);
        cyc(1'b1, 1'b0, 4'd8, 8'h01, 1'b0, '0, 1'b0);
        chk("R8", {7'b0, alm_irq_n}, 8'h01);
        // R2: hour with PM and minute enabled, PM mismatch
        cyc(1'b1, 1'b0, 4'd2, 8'h45, 1'b0, '0, 1'b0);
        cyc(1'b1, 1'b0, 4'd6, 8'h06, 1'b0, '0, 1'b0);
        cyc(1'b1, 1'b0, 4'd1, 8'h12, 1'b0, '0, 1'b0);
        t_hour = 6'h05; t_pm = 1'b0;
        cyc(1'b0, 1'b0, 4'd0, 8'h00, 1'b1, '0, 1'b0);
        chk("R2", {7'b0, alm_irq_n}, 8'h01);
        t_pm = 1'b1;
        cyc(1'b0, 1'b0, 4'd0, 8'h00, 1'b1, '0, 1'b0);
        chk("R2", {7'b0, alm_irq_n}, 8'h00);
        cyc(1'b1, 1'b0, 4'd8, 8'h00, 1'b0, '0, 1'b0);

        // R3: carry select 2
        cyc(1'b1, 1'b0, 4'd7, 8'h20, 1'b0, '0, 1'b0);
        cyc(1'b0, 1'b0, 4'd0, 8'h00, 1'b0, 8'h02, 1'b0);
        chk("R3", {7'b0, per_irq_n}, 8'h01);
        cyc(1'b0, 1'b0, 4'd0, 8'h00, 1'b0, 8'h04, 1'b0);
        chk("R3", {7'b0, per_irq_n}, 8'h00);
        // R9: event beats a write-clear
        cyc(1'b1, 1'b0, 4'd8, 8'h00, 1'b0, 8'h04, 1'b0);
        chk("R9", {7'b0, per_irq_n}, 8'h00);
        // R4: mask holds output high, flag still visible
        cyc(1'b1, 1'b0, 4'd7, 8'h21, 1'b0, '0, 1'b0);
        chk("R4", {7'b0, per_irq_n}, 8'h01);
        cyc(1'b0, 1'b1, 4'd8, 8'h00, 1'b0, '0, 1'b0);
        // R6: pulse of PT ticks
        cyc(1'b1, 1'b0, 4'd8, 8'h00, 1'b0, '0, 1'b1);
        cyc(1'b1, 1'b0, 4'd7, 8'h24, 1'b0, '0, 1'b1);
        cyc(1'b0, 1'b0, 4'd0, 8'h00, 1'b0, 8'h04, 1'b1);
        chk("R6", {7'b0, per_irq_n}, 8'h00);
        for (int k = 1; k < PT; k++) begin
            idle(1'b1);
            chk("R6", {7'b0, per_irq_n}, 8'h00);
        end
        idle(1'b1);
        chk("R6", {7'b0, per_irq_n}, 8'h01);
        // R7: pulse-mode read clears
        cyc(1'b0, 1'b1, 4'd8, 8'h00, 1'b0, '0, 1'b0);
        cyc(1'b0, 1'b1, 4'd8, 8'h00, 1'b0, '0, 1'b0);
        // R9: event beats a read-clear in pulse mode
        cyc(1'b0, 1'b1, 4'd8, 8'h00, 1'b0, 8'h04, 1'b0);
        cyc(1'b0, 1'b1, 4'd8, 8'h00, 1'b0, '0, 1'b0);
        chk("R9", reg_rdata, 8'h00);

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            logic wr, rd, st, osc;
            logic [3:0] a;
            logic [7:0] wd;
            logic [NC-1:0] cy;
            wr = ($urandom % 8) == 0;
            rd = ($urandom % 4) == 0;
            a  = (($urandom % 3) == 0) ? 4'($urandom % 10) : 4'(6 + ($urandom % 3));
            wd = 8'($urandom);
            st = ($urandom % 4) == 0;
            osc = ($urandom % 2) == 0;
            cy = '0;
            for (int b = 0; b < NC; b++) cy[b] = ($urandom % 10) == 0;
            t_sec  = ($urandom % 2) ? m_sec  : 7'($urandom % 4);
            t_min  = ($urandom % 2) ? m_min  : 7'($urandom % 4);
            t_hour = ($urandom % 2) ? m_hour : 6'($urandom % 4);
            t_pm   = ($urandom % 2) ? m_pm   : 1'($urandom);
            t_day  = ($urandom % 2) ? m_day  : 6'($urandom % 4);
            t_mon  = ($urandom % 2) ? m_mon  : 5'($urandom % 4);
            t_wday = ($urandom % 2) ? m_wday : 3'($urandom % 4);
            cyc(wr, rd, a, wd, st, cy, osc);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule